// File: doc/BRIEF.md
# PCIe Receive TLP Qword Data Aligner

This block sits on a 64-bit receive path for PCI Express transaction layer packets. The input is a packed stream of TLP dwords: the header is followed directly by the payload, and each beat carries two dwords. The earlier dword is in bits [31:0] and the later dword is in bits [63:32]. The output is the same stream, rearranged so that every 64-bit payload beat matches one qword of the target memory. Where the payload would otherwise sit in the wrong half of a beat, the block inserts one empty dword slot directly after the header. All later payload then moves forward by one dword, through a single carry register.

The block reads the format field of header dword 0. This tells it whether the header has three or four dwords and whether a payload follows. It then takes address bit 2 from the header dword that holds the low address. For a three-dword header this is dword 2, which holds the request address or the completion lower-address field. For a four-dword header it is dword 3. Completions for configuration or I/O reads carry a lower address of 0, so they always come out aligned.

A single state machine runs the whole flow. `ST_HDR_A` takes the first header beat and raises start-of-packet. `ST_HDR_B` takes the second header beat and chooses the path. It goes to `ST_PASS` when no pad is needed, to `ST_SHIFT` when the payload must move by one dword, and back to `ST_HDR_A` when the packet has already ended. `ST_SHIFT` emits the carried dword together with the next input dword. If one dword is left over after the input's last beat, it goes to `ST_DRAIN`, which emits a final half-empty beat while the input is stalled. `ST_PASS`, `ST_SHIFT` and `ST_DRAIN` all return to `ST_HDR_A` at the end of the packet.

Top module: `tlp_qword_aligner`

## Requirements
- R1: After reset the output is idle (`out_valid` low), and the block is ready to take the first header beat (`in_ready` equals `out_ready`, `out_sop` high).
- R2: The first output beat of every packet is the first input beat, unchanged: header dword 0 in [31:0] and header dword 1 in [63:32], with `out_sop` high. Header dwords are never reordered or byte-swapped.
- R3: The header form is decoded from header dword 0. Bit 29 set means a four-dword header; bit 30 set means a payload is present.
- R4: For a three-dword header whose dword 2 has bit 2 set (address ending in 0x4 or 0xC), no pad is inserted. The first payload dword shares a beat with header dword 2, in bits [63:32].
- R5: For a three-dword header with payload whose dword 2 has bit 2 clear, bits [63:32] of the second beat are an empty slot. The first payload dword lands in bits [31:0] of the third beat.
- R6: For a four-dword header, alignment follows bit 2 of header dword 3. When it is clear, the payload starts in bits [31:0] of the third beat. When it is set, bits [31:0] of the third beat are an empty slot and the payload starts in bits [63:32].
- R7: Completions with data and configuration or I/O writes follow the same rule through bit 2 of header dword 2. A completion with a lower address of 0 is aligned.
- R8: A packet with no payload is never padded, whatever its address bit. `out_eop` is raised on its last header beat.
- R9: `out_eop` marks the beat that holds the last valid dword. `out_empty` is high only on that beat, and only when its bits [63:32] are unused. A one-dword leftover produces an extra final beat.
- R10: Backpressure loses or duplicates no dword. `in_ready` is low whenever `out_ready` is low, and it is also low while the leftover beat is emitted.
- R11: Payload dwords pass through bit for bit. Payload byte 4n stays in the least significant byte of dword n; only the position of whole dwords within beats changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 64 | Packed TLP dwords, earlier dword in [31:0] |
| in_eop | input | 1 | Last input beat of the packet |
| in_empty | input | 1 | Upper dword of the last input beat unused |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 64 | Qword-aligned TLP dwords |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_empty | output | 1 | Upper dword of the last output beat unused |

## Verification
The bench targets single-dword payloads behind a padded three-dword header. A design that mishandled them would drop the only payload dword or report the end of the packet one beat early. It also covers four-dword headers with bit 2 set, where a wrong lane choice would put the first payload dword in the low half and shift every later dword too. Packets without payload are sent with addresses that would trigger a pad if the format bits were ignored, so a stray empty slot appears as an extra beat. A 1024-dword payload under stalls on both sides exposes a carry that is overwritten or re-emitted while the output is blocked.

// File: rtl/tlp_align_pkg.sv
package tlp_align_pkg;

    typedef enum logic [2:0] {
        ST_HDR_A,
        ST_HDR_B,
        ST_PASS,
        ST_SHIFT,
        ST_DRAIN
    } align_state_e;

    typedef enum logic [1:0] {
        SEL_PASS,
        SEL_PAD_HI,
        SEL_SHIFT,
        SEL_TAIL
    } lane_sel_e;

endpackage

// File: rtl/tlp_pad_decide.sv
module tlp_pad_decide (
    input  logic four_dw,
    input  logic has_data,
    input  logic abit_lo,
    input  logic abit_hi,
    output logic pad_hi,
    output logic pad_lo
);
    // Three-dword header: low address lives in the lower dword of beat two.
    // Four-dword header: low address lives in the upper dword of beat two.
    always_comb begin
        pad_hi = has_data && !four_dw && !abit_lo;
        pad_lo = has_data &&  four_dw &&  abit_hi;
    end
endmodule

// File: rtl/tlp_beat_mux.sv
module tlp_beat_mux
    import tlp_align_pkg::*;
#(
    parameter int DWORD_W = 32
) (
    input  lane_sel_e              sel,
    input  logic [2*DWORD_W-1:0]   in_beat,
    input  logic [DWORD_W-1:0]     carry,
    output logic [2*DWORD_W-1:0]   out_beat
);
    localparam int BEAT_W = 2 * DWORD_W;

    logic [DWORD_W-1:0] lo_dw;
    logic [DWORD_W-1:0] hi_dw;

    always_comb begin
        lo_dw = in_beat[DWORD_W-1:0];
        hi_dw = in_beat[BEAT_W-1:DWORD_W];
        unique case (sel)
            SEL_PASS:   out_beat = {hi_dw, lo_dw};
            SEL_PAD_HI: out_beat = {{DWORD_W{1'b0}}, lo_dw};
            SEL_SHIFT:  out_beat = {lo_dw, carry};
            SEL_TAIL:   out_beat = {{DWORD_W{1'b0}}, carry};
            default:    out_beat = {hi_dw, lo_dw};
        endcase
    end
endmodule

// File: rtl/tlp_qword_aligner.sv
module tlp_qword_aligner
    import tlp_align_pkg::*;
#(
    parameter int DWORD_W  = 32,
    parameter int ADDR_BIT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2*DWORD_W-1:0] in_data,
    input  logic                 in_eop,
    input  logic                 in_empty,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [2*DWORD_W-1:0] out_data,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic                 out_empty
);
    localparam int BEAT_W       = 2 * DWORD_W;
    localparam int FMT_DATA_BIT = DWORD_W - 2;
    localparam int FMT_4DW_BIT  = DWORD_W - 3;

    align_state_e       state_q, state_d;
    logic [DWORD_W-1:0] carry_q, carry_d;
    logic               four_q, four_d;
    logic               data_q, data_d;
    lane_sel_e          sel;
    logic               fire;
    logic               pad_hi, pad_lo;
    logic [DWORD_W-1:0] in_lo, in_hi;

    assign in_lo = in_data[DWORD_W-1:0];
    assign in_hi = in_data[BEAT_W-1:DWORD_W];

    tlp_pad_decide u_pad (
        .four_dw (four_q),
        .has_data(data_q),
        .abit_lo (in_lo[ADDR_BIT]),
        .abit_hi (in_hi[ADDR_BIT]),
        .pad_hi  (pad_hi),
        .pad_lo  (pad_lo)
    );

    tlp_beat_mux #(.DWORD_W(DWORD_W)) u_mux (
        .sel     (sel),
        .in_beat (in_data),
        .carry   (carry_q),
        .out_beat(out_data)
    );

    // State and carried-dword registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HDR_A;
            carry_q <= '0;
            four_q  <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            carry_q <= carry_d;
            four_q  <= four_d;
            data_q  <= data_d;
        end
    end

    // Outputs and next state.
    always_comb begin
        sel       = SEL_PASS;
        out_valid = in_valid;
        in_ready  = out_ready;
        out_sop   = 1'b0;
        out_eop   = in_eop;
        out_empty = in_empty;
        state_d   = state_q;
        carry_d   = carry_q;
        four_d    = four_q;
        data_d    = data_q;
        if (state_q == ST_DRAIN) in_ready = 1'b0;
        fire = in_valid && in_ready;

        unique case (state_q)
            ST_HDR_A: begin
                out_sop = 1'b1;
                if (fire) begin
                    four_d  = in_lo[FMT_4DW_BIT];
                    data_d  = in_lo[FMT_DATA_BIT];
                    state_d = ST_HDR_B;
                end
            end
            ST_HDR_B: begin
                if (pad_hi) begin
                    sel       = SEL_PAD_HI;
                    out_eop   = 1'b0;
                    out_empty = 1'b0;
                end
                if (fire) begin
                    if (pad_hi) begin
                        carry_d = in_hi;
                        state_d = in_eop ? ST_DRAIN : ST_SHIFT;
                    end else if (pad_lo) begin
                        carry_d = '0;
                        state_d = ST_SHIFT;
                    end else begin
                        state_d = in_eop ? ST_HDR_A : ST_PASS;
                    end
                end
            end
            ST_PASS: begin
                if (fire && in_eop) state_d = ST_HDR_A;
            end
            ST_SHIFT: begin
                sel       = SEL_SHIFT;
                out_eop   = in_eop && in_empty;
                out_empty = 1'b0;
                if (fire) begin
                    carry_d = in_hi;
                    if (in_eop) state_d = in_empty ? ST_HDR_A : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                sel       = SEL_TAIL;
                out_valid = 1'b1;
                out_eop   = 1'b1;
                out_empty = 1'b1;
                if (out_ready) state_d = ST_HDR_A;
            end
            default: state_d = ST_HDR_A;
        endcase
    end

    // R10: the leftover beat is emitted with the input stalled
    a_r10_drain_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !in_ready);

    // R10: a blocked output never lets an input beat in
    a_r10_no_accept_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !in_ready);

    // R10: carried dword survives a cycle with no input transfer
    a_r10_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !(in_valid && in_ready)) |=> $stable(carry_q));

    // R10: the leftover beat stays put until taken
    a_r10_drain_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !out_ready) |=> (state_q == ST_DRAIN && $stable(carry_q)));

    // R9: an empty upper dword only on a closing beat
    a_r9_empty_needs_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_empty) |-> out_eop);

    // R2: the beat after an accepted end of packet starts a new packet
    a_r2_sop_follows_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> out_sop);

endmodule

// File: tb/tb_tlp_qword_aligner.sv
module tb_tlp_qword_aligner;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_data;
    logic        in_eop;
    logic        in_empty;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_empty;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seq    = 0;

    logic [31:0] in_d  [0:1031];
    logic [32:0] exp_s [0:1035];

    always #4 clk = ~clk;

    tlp_qword_aligner dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Send one TLP and compare every output beat against the expected slot map.
    task automatic run_tlp(input logic [2:0] fmt, input logic [4:0] typ,
                           input logic [31:0] addr, input logic [9:0] len,
                           input int rdy_mode, input int vld_mode, input string tag);
        bit is4 = fmt[0];
        bit hasd = fmt[1];
        int nd = hasd ? ((len == 10'd0) ? 1024 : int'(len)) : 0;
        int nh = is4 ? 4 : 3;
        int n_in = nh + nd;
        bit pad = hasd && (is4 ? addr[2] : !addr[2]);
        int n_s = 0;
        int n_ib, n_ob;
        int ib = 0;
        int ob = 0;
        int guard = 0;
        seq++;
        in_d[0] = {fmt, typ, 14'h0000, len};
        in_d[1] = 32'h0100_00FF;
        if (is4) in_d[2] = 32'h0000_0000;
        in_d[nh-1] = addr;
        for (int k = 0; k < nd; k++) in_d[nh+k] = {4'hD, seq[11:0], k[15:0]};
        for (int j = 0; j < nh; j++) begin exp_s[n_s] = {1'b1, in_d[j]}; n_s++; end
        if (pad) begin exp_s[n_s] = 33'h0; n_s++; end
        for (int k = 0; k < nd; k++) begin exp_s[n_s] = {1'b1, in_d[nh+k]}; n_s++; end
        n_ib = (n_in + 1) / 2;
        n_ob = (n_s + 1) / 2;
        while (ob < n_ob && guard < 5000) begin
            @(negedge clk);
            cyc++;
            guard++;
            in_valid  = (ib < n_ib) && (vld_mode == 0 || (cyc % 2) == 0);
            in_data   = {(2*ib+1 < n_in) ? in_d[2*ib+1] : 32'h0, in_d[2*ib]};
            in_eop    = (ib == n_ib - 1);
            in_empty  = (ib == n_ib - 1) && (n_in % 2 == 1);
            out_ready = (rdy_mode == 0) || ((cyc % 3) != 0);
            #1;
            if (!out_ready)
                check(!in_ready, "R10", {tag, " in_ready while blocked"}, 64'(in_ready), 64'd0);
            if (out_valid && out_ready) begin
                bit last = (ob == n_ob - 1);
                bit xe = last && (n_s % 2 == 1);
                string dt = (ob == 0) ? "R2" : tag;
                check(out_sop == (ob == 0), "R2", {tag, " sop"}, 64'(out_sop), 64'(ob == 0));
                check(out_eop == last, "R9", {tag, " eop"}, 64'(out_eop), 64'(last));
                check(out_empty == xe, "R9", {tag, " empty"}, 64'(out_empty), 64'(xe));
                if (exp_s[2*ob][32])
                    check(out_data[31:0] == exp_s[2*ob][31:0], dt, {tag, " low dword"},
                          64'(out_data[31:0]), 64'(exp_s[2*ob][31:0]));
                if (2*ob+1 < n_s && exp_s[2*ob+1][32])
                    check(out_data[63:32] == exp_s[2*ob+1][31:0], dt, {tag, " high dword"},
                          64'(out_data[63:32]), 64'(exp_s[2*ob+1][31:0]));
                ob++;
            end
            if (in_valid && in_ready) ib++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        check(ob == n_ob, "R10", {tag, " output beats"}, 64'(ob), 64'(n_ob));
        check(ib == n_ib, "R10", {tag, " input beats"}, 64'(ib), 64'(n_ib));
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready,   "R1", "in_ready after reset",  64'(in_ready),  64'd1);
        check(out_sop,    "R1", "sop after reset",       64'(out_sop),   64'd1);
    endtask

    task automatic t_3dw_shifted();  // R4
        run_tlp(3'b010, 5'b00000, 32'h0000_1004, 10'd5, 0, 0, "R4");
        run_tlp(3'b010, 5'b00000, 32'h0000_100C, 10'd2, 0, 0, "R4");
    endtask

    task automatic t_3dw_padded();   // R5
        run_tlp(3'b010, 5'b00000, 32'h0000_2000, 10'd4, 0, 0, "R5");
        run_tlp(3'b010, 5'b00000, 32'h0000_2008, 10'd1, 0, 0, "R5");
        run_tlp(3'b010, 5'b00000, 32'h0000_2010, 10'd3, 0, 0, "R5");
    endtask

    task automatic t_4dw();          // R6
        run_tlp(3'b011, 5'b00000, 32'h0000_3000, 10'd3, 0, 0, "R6");
        run_tlp(3'b011, 5'b00000, 32'h0000_300C, 10'd4, 0, 0, "R6");
        run_tlp(3'b011, 5'b00000, 32'h0000_3004, 10'd1, 0, 0, "R6");
    endtask

    task automatic t_cpl_cfg_io();   // R7
        run_tlp(3'b010, 5'b01010, 32'h0000_0044, 10'd2, 0, 0, "R7");
        run_tlp(3'b010, 5'b01010, 32'h0000_0000, 10'd1, 0, 0, "R7");
        run_tlp(3'b010, 5'b00100, 32'h0000_0004, 10'd1, 0, 0, "R7");
        run_tlp(3'b010, 5'b00010, 32'h0000_0010, 10'd1, 0, 0, "R7");
    endtask

    task automatic t_no_payload();   // R3, R8
        run_tlp(3'b000, 5'b00000, 32'h0000_4000, 10'd4, 0, 0, "R8");
        run_tlp(3'b001, 5'b00000, 32'h0000_4004, 10'd2, 0, 0, "R3");
        run_tlp(3'b000, 5'b01010, 32'h0000_0000, 10'd0, 0, 0, "R8");
    endtask

    task automatic t_byte_order();   // R11
        run_tlp(3'b010, 5'b00000, 32'h0000_5008, 10'd6, 0, 0, "R11");
    endtask

    task automatic t_backpressure(); // R10
        run_tlp(3'b010, 5'b00000, 32'h0000_6000, 10'd7, 1, 1, "R10");
        run_tlp(3'b010, 5'b00000, 32'h0000_6000, 10'd1, 1, 0, "R10");
        run_tlp(3'b011, 5'b00000, 32'h0000_6004, 10'd6, 1, 1, "R10");
        run_tlp(3'b010, 5'b00000, 32'h0000_6004, 10'd3, 0, 1, "R10");
    endtask

    task automatic t_long();         // R9: length field 0 is 1024 dwords
        run_tlp(3'b010, 5'b00000, 32'h0000_7000, 10'd0, 1, 1, "R9");
    endtask

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = '0;
        in_eop    = 1'b0;
        in_empty  = 1'b0;
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_3dw_shifted();
        t_3dw_padded();
        t_4dw();
        t_cpl_cfg_io();
        t_no_payload();
        t_byte_order();
        t_backpressure();
        t_long();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule